// File: doc/BRIEF.md
# Per-Port Credit Refill Manager

This block keeps the enqueue credit count of a group of producer ports that all draw from one shared credit pool. A port may only enqueue an event while it holds a credit, and every accepted enqueue costs that port one credit. When the downstream consumer releases an event, its credit goes back into the shared pool. The block then moves credits from the pool back into ports that are running low, with no software involvement.

Each port's thresholds come from its configured enqueue depth. The depth is the port's ceiling, or high watermark. Half the depth, rounded down, is the refill quantum. The smaller of the quantum and a fixed cap of 16 is the low watermark. A start pulse loads every port to its full depth and takes those credits out of the pool. After that, any port whose count drops below its low watermark asks for a refill. One refill is granted per cycle, and the requesting ports are served in rotation.

Producers drive a per-port request and get back an accept or reject in the same cycle. Release pulses come one per port lane per cycle. The port counts and the pool count are visible at the outputs.

Top module: `crm_credit_mgr`

## Requirements
- R1: After reset the pool output equals POOL_SIZE and every port count is 0. Until the first start pulse, every enqueue request is rejected and no refill takes place.
- R2: In the cycle after start_i, each port count equals that port's depth and the pool equals POOL_SIZE minus the sum of all depths. An enqueue requested in the start cycle itself is rejected.
- R3: A requesting port gets enq_ack_o high in the same cycle exactly when the block has been started, start_i is low and the port count is nonzero. Otherwise a requesting port gets enq_rej_o high. A port that is not requesting sees both outputs low.
- R4: Each accepted enqueue lowers that port's count by exactly one in the following cycle, on top of any refill the port receives in the same cycle.
- R5: For a port of depth D, the quantum is floor(D/2) and the low watermark is min(16, floor(D/2)). A started port asks for a refill while its count is strictly below its low watermark and the pool is nonzero.
- R6: A granted port gains min(quantum, pool) credits in the next cycle. If the pool holds less than a quantum, the port takes all that is left. A port count never exceeds its depth.
- R7: At most one port is refilled per cycle. The search for a requester starts at the port after the one last granted, with port 0 following port NUM_PORTS-1, and port 0 is searched first after reset.
- R8: Each set bit of release_i adds one credit to the pool in the next cycle.
- R9: The pool, plus the sum of port counts, plus the number of accepted events not yet released, always equals POOL_SIZE.
- R10: While the pool is zero, no port count grows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that loads every port to its depth |
| depth_cfg_i | input | NUM_PORTS*DEPTH_W | Enqueue depth per port, port p at bits [p*DEPTH_W +: DEPTH_W] |
| enq_req_i | input | NUM_PORTS | Enqueue attempt per port |
| release_i | input | NUM_PORTS | One released event per set bit |
| enq_ack_o | output | NUM_PORTS | Enqueue accepted this cycle |
| enq_rej_o | output | NUM_PORTS | Enqueue rejected this cycle, retry later |
| port_credits_o | output | NUM_PORTS*DEPTH_W | Credit count per port, same packing as depth_cfg_i |
| pool_credits_o | output | $clog2(POOL_SIZE+1) | Credits left in the shared pool |

## Verification
The assertions assume that the environment behaves within these limits. The number of release pulses never exceeds the number of accepted events still outstanding. Start is pulsed only when no events are outstanding. Depths change only in the cycle that carries the start pulse, and the sum of depths fits in the pool. The stimulus stays inside these limits by design. It keeps its own count of outstanding events and sets release bits only up to that count. It drains every outstanding event before it changes the depths, and it changes them together with the start pulse. The depth mixes it uses include odd values and small quanta, so that the pool runs out part way through a quantum.

// File: rtl/crm_pkg.sv
`timescale 1ns/1ps
package crm_pkg;
  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_LIVE = 1'b1
  } run_state_e;
endpackage

// File: rtl/crm_wm_calc.sv
`timescale 1ns/1ps
module crm_wm_calc #(
  parameter int DEPTH_W = 8,
  parameter int LOW_CAP = 16
) (
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [DEPTH_W-1:0] quantum_o,
  output logic [DEPTH_W-1:0] low_o
);
  localparam logic [DEPTH_W-1:0] CAP = DEPTH_W'(LOW_CAP);

  always_comb begin
    quantum_o = depth_i >> 1;
    low_o     = (quantum_o < CAP) ? quantum_o : CAP;
  end
endmodule

// File: rtl/crm_rr_arb.sv
`timescale 1ns/1ps
module crm_rr_arb #(
  parameter int N = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N-1:0]                    req_i,
  output logic [N-1:0]                    gnt_o,
  output logic [(N > 1 ? $clog2(N) : 1)-1:0] idx_o,
  output logic                            vld_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (!vld_o && req_i[(int'(ptr_q) + i) % N]) begin
        vld_o = 1'b1;
        idx_o = IDX_W'((int'(ptr_q) + i) % N);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) gnt_o[i] = vld_o && (idx_o == IDX_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (vld_o) ptr_q <= (idx_o == IDX_W'(N - 1)) ? '0 : idx_o + 1'b1;
  end
endmodule

// File: rtl/crm_port_ctr.sv
`timescale 1ns/1ps
module crm_port_ctr #(
  parameter int DEPTH_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               run_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic               enq_req_i,
  input  logic               add_en_i,
  input  logic [DEPTH_W-1:0] add_amt_i,
  output logic [DEPTH_W-1:0] cnt_o,
  output logic               ack_o,
  output logic               rej_o
);
  logic [DEPTH_W-1:0] cnt_q;
  logic [DEPTH_W-1:0] cnt_d;

  assign ack_o = enq_req_i && run_i && (cnt_q != '0);
  assign rej_o = enq_req_i && !ack_o;
  assign cnt_o = cnt_q;

  always_comb begin
    if (load_i) cnt_d = depth_i;
    else cnt_d = cnt_q - DEPTH_W'(ack_o) + (add_en_i ? add_amt_i : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else cnt_q <= cnt_d;
  end
endmodule

// File: rtl/crm_credit_mgr.sv
`timescale 1ns/1ps
module crm_credit_mgr #(
  parameter int NUM_PORTS = 4,
  parameter int DEPTH_W   = 8,
  parameter int POOL_SIZE = 4096,
  parameter int LOW_CAP   = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [NUM_PORTS*DEPTH_W-1:0]   depth_cfg_i,
  input  logic [NUM_PORTS-1:0]           enq_req_i,
  input  logic [NUM_PORTS-1:0]           release_i,
  output logic [NUM_PORTS-1:0]           enq_ack_o,
  output logic [NUM_PORTS-1:0]           enq_rej_o,
  output logic [NUM_PORTS*DEPTH_W-1:0]   port_credits_o,
  output logic [$clog2(POOL_SIZE+1)-1:0] pool_credits_o
);
  import crm_pkg::*;

  localparam int POOL_W = $clog2(POOL_SIZE + 1);
  localparam int IDX_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int SUM_W  = DEPTH_W + IDX_W + 1;
  localparam int WIDE_W = ((POOL_W > SUM_W) ? POOL_W : SUM_W) + 1;

  run_state_e         state_q;
  logic               run;
  logic [POOL_W-1:0]  pool_q;
  logic [POOL_W-1:0]  pool_d;
  logic [SUM_W-1:0]   depth_sum;
  logic [WIDE_W-1:0]  pool_load;

  logic [DEPTH_W-1:0] depth   [NUM_PORTS];
  logic [DEPTH_W-1:0] quantum [NUM_PORTS];
  logic [DEPTH_W-1:0] low_wm  [NUM_PORTS];
  logic [DEPTH_W-1:0] cnt     [NUM_PORTS];
  logic [NUM_PORTS-1:0] refill_req;
  logic [NUM_PORTS-1:0] grant;
  logic [IDX_W-1:0]     grant_idx;
  logic                 grant_vld;
  logic [DEPTH_W-1:0]   q_sel;
  logic [DEPTH_W-1:0]   grant_amt;

  assign run = (state_q == RUN_LIVE) && !start_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign depth[p] = depth_cfg_i[p*DEPTH_W +: DEPTH_W];

    crm_wm_calc #(.DEPTH_W(DEPTH_W), .LOW_CAP(LOW_CAP)) u_wm (
      .depth_i   (depth[p]),
      .quantum_o (quantum[p]),
      .low_o     (low_wm[p])
    );

    assign refill_req[p] = run && (cnt[p] < low_wm[p]) && (pool_q != '0);

    crm_port_ctr #(.DEPTH_W(DEPTH_W)) u_ctr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (start_i),
      .run_i     (run),
      .depth_i   (depth[p]),
      .enq_req_i (enq_req_i[p]),
      .add_en_i  (grant[p]),
      .add_amt_i (grant_amt),
      .cnt_o     (cnt[p]),
      .ack_o     (enq_ack_o[p]),
      .rej_o     (enq_rej_o[p])
    );

    assign port_credits_o[p*DEPTH_W +: DEPTH_W] = cnt[p];
  end

  crm_rr_arb #(.N(NUM_PORTS)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (refill_req),
    .gnt_o  (grant),
    .idx_o  (grant_idx),
    .vld_o  (grant_vld)
  );

  // take the remainder when the pool is shorter than a quantum
  always_comb begin
    q_sel     = quantum[grant_idx];
    grant_amt = (pool_q >= POOL_W'(q_sel)) ? q_sel : DEPTH_W'(pool_q);
  end

  always_comb begin
    depth_sum = '0;
    for (int p = 0; p < NUM_PORTS; p++) depth_sum = depth_sum + SUM_W'(depth[p]);
    pool_load = WIDE_W'(POOL_SIZE) - WIDE_W'(depth_sum);
  end

  always_comb begin
    if (start_i) pool_d = POOL_W'(pool_load);
    else pool_d = pool_q - (grant_vld ? POOL_W'(grant_amt) : '0)
                         + POOL_W'($countones(release_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RUN_IDLE;
      pool_q  <= POOL_W'(POOL_SIZE);
    end else begin
      if (start_i) state_q <= RUN_LIVE;
      pool_q <= pool_d;
    end
  end

  assign pool_credits_o = pool_q;
endmodule

// File: rtl/crm_credit_mgr_chk.sv
`timescale 1ns/1ps
module crm_credit_mgr_chk #(
  parameter int NUM_PORTS = 4,
  parameter int DEPTH_W   = 8,
  parameter int POOL_SIZE = 4096
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           start_i,
  input logic [NUM_PORTS*DEPTH_W-1:0]   depth_cfg_i,
  input logic [NUM_PORTS-1:0]           enq_req_i,
  input logic [NUM_PORTS-1:0]           enq_ack_o,
  input logic [NUM_PORTS-1:0]           enq_rej_o,
  input logic [NUM_PORTS*DEPTH_W-1:0]   port_credits_o,
  input logic [$clog2(POOL_SIZE+1)-1:0] pool_credits_o,
  input logic [NUM_PORTS-1:0]           grant_i
);
  assert_single_refill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_i));

  assert_pool_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pool_credits_o <= ($clog2(POOL_SIZE+1))'(POOL_SIZE));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    assert_ack_needs_credit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      enq_ack_o[p] |-> (enq_req_i[p] && port_credits_o[p*DEPTH_W +: DEPTH_W] != '0));

    assert_ack_rej_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(enq_ack_o[p] && enq_rej_o[p]));

    assert_load_depth_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> port_credits_o[p*DEPTH_W +: DEPTH_W] == $past(depth_cfg_i[p*DEPTH_W +: DEPTH_W]));

    assert_one_per_enq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enq_ack_o[p] && !grant_i[p] && !start_i) |=>
        port_credits_o[p*DEPTH_W +: DEPTH_W] == $past(port_credits_o[p*DEPTH_W +: DEPTH_W]) - 1'b1);

    assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |-> port_credits_o[p*DEPTH_W +: DEPTH_W] <= depth_cfg_i[p*DEPTH_W +: DEPTH_W]);
  end
endmodule

bind crm_credit_mgr crm_credit_mgr_chk #(
  .NUM_PORTS (NUM_PORTS),
  .DEPTH_W   (DEPTH_W),
  .POOL_SIZE (POOL_SIZE)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .depth_cfg_i    (depth_cfg_i),
  .enq_req_i      (enq_req_i),
  .enq_ack_o      (enq_ack_o),
  .enq_rej_o      (enq_rej_o),
  .port_credits_o (port_credits_o),
  .pool_credits_o (pool_credits_o),
  .grant_i        (grant)
);

// File: tb/crm_credit_mgr_test.sv
`timescale 1ns/1ps
module crm_credit_mgr_test;
  localparam int N   = 4;
  localparam int DW  = 8;
  localparam int PS  = 4096;
  localparam int PW  = $clog2(PS + 1);
  localparam int CAP = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [N*DW-1:0] depth_cfg_i = '0;
  logic [N-1:0]  enq_req_i = '0;
  logic [N-1:0]  release_i = '0;
  logic [N-1:0]  enq_ack_o;
  logic [N-1:0]  enq_rej_o;
  logic [N*DW-1:0] port_credits_o;
  logic [PW-1:0] pool_credits_o;

  int n_vec = 0;
  int n_bad = 0;
  int dep[N];
  int mcnt[N];
  int mpool = PS;
  int mptr = 0;
  int inflight = 0;
  bit mrun = 1'b0;

  always #5 clk_i = ~clk_i;

  crm_credit_mgr #(.NUM_PORTS(N), .DEPTH_W(DW), .POOL_SIZE(PS), .LOW_CAP(CAP)) uut (
    .clk_i, .rst_ni, .start_i, .depth_cfg_i, .enq_req_i, .release_i,
    .enq_ack_o, .enq_rej_o, .port_credits_o, .pool_credits_o
  );

  function automatic int cnt_of(int p);
    return int'(port_credits_o[p*DW +: DW]);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock: drive, compare against model, advance model
  task automatic step(bit st, logic [N-1:0] eq, logic [N-1:0] rl);
    int total;
    int g;
    int amt;
    int nrel;
    bit a;
    @(negedge clk_i);
    start_i = st;
    enq_req_i = eq;
    release_i = rl;
    for (int p = 0; p < N; p++) depth_cfg_i[p*DW +: DW] = DW'(dep[p]);
    #1;
    total = int'(pool_credits_o) + inflight;
    for (int p = 0; p < N; p++) begin
      a = mrun && !st && eq[p] && (mcnt[p] > 0);
      chk($sformatf("R3 ack port %0d", p), int'(enq_ack_o[p]), int'(a));
      chk($sformatf("R3 rej port %0d", p), int'(enq_rej_o[p]), int'(eq[p] && !a));
      chk($sformatf("R4 R5 R6 R7 count port %0d", p), cnt_of(p), mcnt[p]);
      total += cnt_of(p);
    end
    chk("R8 R10 pool", int'(pool_credits_o), mpool);
    chk("R9 conservation", total, PS);
    nrel = $countones(rl);
    if (st) begin
      mrun = 1'b1;
      mpool = PS;
      for (int p = 0; p < N; p++) begin
        mcnt[p] = dep[p];
        mpool -= dep[p];
      end
    end else begin
      g = -1;
      if (mrun && mpool > 0) begin
        for (int i = 0; i < N; i++) begin
          int j;
          int lw;
          j = (mptr + i) % N;
          lw = (dep[j] / 2 < CAP) ? dep[j] / 2 : CAP;
          if (g < 0 && mcnt[j] < lw) g = j;
        end
      end
      for (int p = 0; p < N; p++) begin
        if (mrun && eq[p] && mcnt[p] > 0) begin
          mcnt[p]--;
          inflight++;
        end
      end
      amt = 0;
      if (g >= 0) begin
        amt = (dep[g] / 2 < mpool) ? dep[g] / 2 : mpool;
        mcnt[g] += amt;
        mptr = (g + 1) % N;
      end
      mpool = mpool - amt + nrel;
      inflight -= nrel;
    end
  endtask

  function automatic logic [N-1:0] pick_rel(int budget);
    logic [N-1:0] r = '0;
    int c = 0;
    for (int p = 0; p < N; p++) begin
      if ($urandom_range(1, 0) == 1 && c < budget) begin
        r[p] = 1'b1;
        c++;
      end
    end
    return r;
  endfunction

  task automatic drain_all();
    while (inflight > 0) step(1'b0, '0, pick_rel(inflight));
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < N; p++) begin
      dep[p] = 32;
      mcnt[p] = 0;
    end
    #12 rst_ni = 1'b1;

    step(1'b0, '0, '0);
    chk("R1 pool after reset", int'(pool_credits_o), PS);
    for (int p = 0; p < N; p++) chk("R1 count after reset", cnt_of(p), 0);
    step(1'b0, '1, '0);
    chk("R1 reject before start", int'(enq_rej_o), 15);
    step(1'b0, '0, '0);

    step(1'b1, '1, '0);
    chk("R2 reject in start cycle", int'(enq_ack_o), 0);
    step(1'b0, '0, '0);
    chk("R2 pool after load", int'(pool_credits_o), 3968);
    for (int p = 0; p < N; p++) chk("R2 count after load", cnt_of(p), 32);

    repeat (17) step(1'b0, 4'b0001, '0);
    step(1'b0, '0, '0);
    chk("R5 below low watermark", cnt_of(0), 15);
    step(1'b0, '0, '0);
    chk("R6 quantum refill", cnt_of(0), 31);
    chk("R6 pool after refill", int'(pool_credits_o), 3952);

    repeat (1800) step(1'b0, N'($urandom | $urandom), '0);
    chk("R10 pool exhausted", int'(pool_credits_o), 0);
    for (int p = 0; p < N; p++) chk("R10 port empty", cnt_of(p), 0);
    drain_all();

    dep[0] = 20; dep[1] = 7; dep[2] = 40; dep[3] = 3;
    step(1'b1, '0, '0);
    step(1'b0, '0, '0);
    chk("R2 pool after reload", int'(pool_credits_o), PS - 70);

    repeat (2000) step(1'b0, N'($urandom | $urandom), '0);
    drain_all();

    dep[0] = 255; dep[1] = 9; dep[2] = 64; dep[3] = 33;
    step(1'b1, '0, '0);
    repeat (3000) step(1'b0, N'($urandom), pick_rel(inflight));
    drain_all();
    step(1'b0, '0, '0);
    chk("R9 all credits home", int'(pool_credits_o) + cnt_of(0) + cnt_of(1) + cnt_of(2) + cnt_of(3), PS);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule